// File: doc/BRIEF.md
# Quasi-Resonant Switching Period Controller

This block is the digital timing core for the second stage of a peak-current, quasi-resonant power converter. Analog comparators outside the block report five conditions: switch current at the peak threshold, switch current at the overcurrent level, switch current above a minimum level, auxiliary-winding overvoltage, and auxiliary-winding zero-current detect. The block drives one registered gate output. Each switching cycle starts with an on phase that ends on the peak comparator. The on phase is bounded by leading-edge blanking and by minimum and maximum on-times. The off phase then measures the demagnetization interval T2, from the gate falling edge to the first unblanked zero-current detect.

The total switching period is T2 multiplied by a gain ratio and divided by a dimming factor in the range 0 to 1. The result is clamped to a minimum and a maximum period. The next turn-on waits until this period has expired and a zero-current detect has also been seen. If no zero-current detect arrives, the maximum period forces a turn-on. A dimming factor of zero holds the gate off. Overcurrent, overvoltage and a missing minimum-level crossing are all faults. Each fault shuts the gate off, and a fixed retry delay must pass before the block restarts. All times are clock-cycle counts given as parameters. The defaults assume a 50 MHz clock: blanking 28, on-time 28 to 440, zero-current blanking 100, period 250 to 80000, retry 50,000,000 cycles.

Top module: `qrp_ctrl`

## Requirements
- R1: While `rst` is high, `gate_o` is 0. On the first rising clock edge after `rst` falls, `gate_o` goes high if `dim_code_i` is nonzero.
- R2: Let k be the on-phase cycle index, with 0 for the first cycle after the rising edge. The peak input counts only when k >= LEB_CYC. The gate falls after cycle k = max(first counted peak cycle, TON_MIN_CYC-1), capped at TON_MAX_CYC-1. The on-time is therefore k+1 cycles.
- R3: The period P, counted between rising edges, is the largest of three values: PER_MIN_CYC, on-time + T2 + 2, and ceil(T2·gain_code·2^DIM_FRAC / (dim_eff·2^GAIN_FRAC)). P is then limited to at most PER_MAX_CYC.
- R4: T2 is the off-phase cycle index, with 0 for the first cycle after the falling edge, at which zero-current detect is first seen. Detect is ignored for indices below ZCD_BLANK_CYC.
- R5: `gain_code_i` is unsigned with GAIN_FRAC fraction bits. `dim_code_i` is unsigned with DIM_FRAC fraction bits. dim_eff is `dim_code_i`, saturated at 2^DIM_FRAC (which means 1.0).
- R6: Overcurrent is checked at on-phase index k >= LEB_CYC. It drops the gate after that cycle. The gate then stays low for RETRY_CYC+1 cycles and turns on again, giving a period of k+2+RETRY_CYC.
- R7: If the minimum-level input is never seen at index k >= LEB_CYC before the on phase ends, a fault follows that on phase. The gate stays low for RETRY_CYC+1 cycles, giving a period of on-time + RETRY_CYC + 1.
- R8: Overvoltage is checked at off-phase index j >= ZCD_BLANK_CYC and is ignored earlier. A trip gives a period of on-time + j + 2 + RETRY_CYC.
- R9: While `dim_code_i` is 0, no new rising edge occurs. After it becomes nonzero following a wait of at least PER_MAX_CYC, the gate rises on the next clock edge.
- R10: With no zero-current detect, the period is exactly PER_MAX_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_peak_i | input | 1 | Switch current reached peak threshold |
| sense_ocp_i | input | 1 | Switch current above overcurrent level |
| sense_min_i | input | 1 | Switch current above minimum level |
| aux_ovp_i | input | 1 | Auxiliary winding above overvoltage level |
| aux_zcd_i | input | 1 | Auxiliary winding zero-current detect |
| gain_code_i | input | GAIN_W | Period-to-T2 gain, GAIN_FRAC fraction bits |
| dim_code_i | input | DIM_W | Dimming factor, DIM_FRAC fraction bits |
| gate_o | output | 1 | Registered gate drive |

## Verification
Every internal quantity shows up in the gate edges within one switching period.
- A wrong blanking or on-time bound changes the length of the next high pulse.
- A miscounted T2, a wrong gain or dim product, or a wrong clamp moves the next rising edge.
- A broken fault path shows as a low interval that is missing, or whose length differs from the retry delay.

The bench sweeps gain, dim, detect timing and peak timing over a small configuration. It measures pulse and period lengths from the gate alone.

// File: rtl/qrp_pkg.sv
package qrp_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ON    = 2'd1,
    ST_FAULT = 2'd2
  } qrp_state_e;
endpackage

// File: rtl/qrp_ontime.sv
module qrp_ontime #(
  parameter int LEB_CYC     = 28,
  parameter int TON_MIN_CYC = 28,
  parameter int TON_MAX_CYC = 440,
  parameter int TW          = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          on_active,
  input  logic [TW-1:0] tcnt,
  input  logic          cmp_peak,
  input  logic          cmp_ocp,
  input  logic          cmp_min,
  output logic          end_on,
  output logic          ocp_trip,
  output logic          olp_trip
);
  logic peak_seen_q, min_seen_q;
  logic past_blank, peak_now, min_now, min_ok, max_hit;

  always_comb begin
    past_blank = on_active && (tcnt >= TW'(LEB_CYC));
    peak_now   = peak_seen_q || (past_blank && cmp_peak);
    min_now    = min_seen_q || (past_blank && cmp_min);
    min_ok     = tcnt >= TW'(TON_MIN_CYC - 1);
    max_hit    = tcnt >= TW'(TON_MAX_CYC - 1);
    end_on     = on_active && ((peak_now && min_ok) || max_hit);
    ocp_trip   = past_blank && cmp_ocp;
    olp_trip   = end_on && !min_now;
  end

  always_ff @(posedge clk) begin
    if (rst || arm) begin
      peak_seen_q <= 1'b0;
      min_seen_q  <= 1'b0;
    end else if (past_blank) begin
      peak_seen_q <= peak_seen_q | cmp_peak;
      min_seen_q  <= min_seen_q | cmp_min;
    end
  end

  // R2: the on phase never ends inside the blanking window
  assert_no_end_in_blank_R2: assert property (@(posedge clk) disable iff (rst)
    (on_active && tcnt < TW'(LEB_CYC) && tcnt < TW'(TON_MAX_CYC - 1)) |-> !end_on);
endmodule

// File: rtl/qrp_demag.sv
module qrp_demag #(
  parameter int ZCD_BLANK_CYC = 100,
  parameter int CAP_CYC       = 80000,
  parameter int TW            = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm_off,
  input  logic          clr,
  input  logic          off_active,
  input  logic          zcd_in,
  input  logic          ovp_in,
  output logic          zcd_seen,
  output logic [TW-1:0] t2,
  output logic          ovp_trip
);
  logic [TW-1:0] dcnt_q, t2_q;
  logic          seen_q, zvalid;

  always_comb begin
    zvalid   = off_active && (dcnt_q >= TW'(ZCD_BLANK_CYC));
    ovp_trip = zvalid && ovp_in;
    zcd_seen = seen_q;
    t2       = t2_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt_q <= TW'(CAP_CYC);
      seen_q <= 1'b0;
      t2_q   <= '0;
    end else if (clr) begin
      dcnt_q <= TW'(CAP_CYC);
      seen_q <= 1'b0;
    end else if (arm_off) begin
      dcnt_q <= '0;
      seen_q <= 1'b0;
    end else begin
      if (off_active && dcnt_q != TW'(CAP_CYC)) dcnt_q <= dcnt_q + TW'(1);
      if (zvalid && zcd_in && !seen_q) begin
        seen_q <= 1'b1;
        t2_q   <= dcnt_q;
      end
    end
  end

  assert_t2_floor_R4: assert property (@(posedge clk) disable iff (rst)
    zcd_seen |-> (t2 >= TW'(ZCD_BLANK_CYC)));
endmodule

// File: rtl/qrp_period.sv
module qrp_period #(
  parameter int PER_MIN_CYC = 250,
  parameter int PER_MAX_CYC = 80000,
  parameter int TW          = 17,
  parameter int GAIN_W      = 8,
  parameter int GAIN_FRAC   = 4,
  parameter int DIM_W       = 9,
  parameter int DIM_FRAC    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              preload,
  input  logic              zcd_seen,
  input  logic [TW-1:0]     t2,
  input  logic [GAIN_W-1:0] gain_code,
  input  logic [DIM_W-1:0]  dim_code,
  output logic [TW-1:0]     tcnt,
  output logic              on_ok
);
  localparam int PW = TW + GAIN_W + DIM_W + GAIN_FRAC + DIM_FRAC + 1;
  localparam logic [DIM_W-1:0] DIM_ONE = DIM_W'(1) << DIM_FRAC;

  logic [TW-1:0]    tcnt_q;
  logic [DIM_W-1:0] dim_eff;
  logic [PW-1:0]    next_p, lhs, rhs;
  logic             forced, law_met;

  always_comb begin
    dim_eff = (dim_code > DIM_ONE) ? DIM_ONE : dim_code;
    next_p  = PW'(tcnt_q) + PW'(1);
    lhs     = (next_p * PW'(dim_eff)) << GAIN_FRAC;
    rhs     = (PW'(t2) * PW'(gain_code)) << DIM_FRAC;
    forced  = tcnt_q >= TW'(PER_MAX_CYC - 1);
    law_met = zcd_seen && (next_p >= PW'(PER_MIN_CYC)) && (lhs >= rhs);
    on_ok   = (dim_code != '0) && (forced || law_met);
    tcnt    = tcnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst || preload)                    tcnt_q <= TW'(PER_MAX_CYC);
    else if (restart)                      tcnt_q <= '0;
    else if (tcnt_q != TW'(PER_MAX_CYC))   tcnt_q <= tcnt_q + TW'(1);
  end
endmodule

// File: rtl/qrp_retry.sv
module qrp_retry #(
  parameter int RETRY_CYC = 50000000,
  parameter int RW        = 26
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done,
  output logic busy
);
  logic [RW-1:0] cnt_q;
  logic          run_q;

  always_comb begin
    done = run_q && (cnt_q == RW'(RETRY_CYC - 1));
    busy = run_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (done) run_q <= 1'b0;
      else      cnt_q <= cnt_q + RW'(1);
    end
  end
endmodule

// File: rtl/qrp_ctrl.sv
module qrp_ctrl
  import qrp_pkg::*;
#(
  parameter int LEB_CYC       = 28,
  parameter int TON_MIN_CYC   = 28,
  parameter int TON_MAX_CYC   = 440,
  parameter int ZCD_BLANK_CYC = 100,
  parameter int PER_MIN_CYC   = 250,
  parameter int PER_MAX_CYC   = 80000,
  parameter int RETRY_CYC     = 50000000,
  parameter int GAIN_W        = 8,
  parameter int GAIN_FRAC     = 4,
  parameter int DIM_W         = 9,
  parameter int DIM_FRAC      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sense_peak_i,
  input  logic              sense_ocp_i,
  input  logic              sense_min_i,
  input  logic              aux_ovp_i,
  input  logic              aux_zcd_i,
  input  logic [GAIN_W-1:0] gain_code_i,
  input  logic [DIM_W-1:0]  dim_code_i,
  output logic              gate_o
);
  localparam int TW = $clog2(PER_MAX_CYC + 1);
  localparam int RW = $clog2(RETRY_CYC + 1);

  qrp_state_e    state_q, state_n;
  logic          gate_q;
  logic          turn_on, turn_off, fault_go;
  logic          end_on, ocp_trip, olp_trip;
  logic          zcd_seen, ovp_trip, on_ok, retry_done, retry_busy;
  logic [TW-1:0] tcnt, t2;

  qrp_ontime #(
    .LEB_CYC(LEB_CYC), .TON_MIN_CYC(TON_MIN_CYC), .TON_MAX_CYC(TON_MAX_CYC), .TW(TW)
  ) u_ontime (
    .clk(clk), .rst(rst), .arm(turn_on), .on_active(state_q == ST_ON), .tcnt(tcnt),
    .cmp_peak(sense_peak_i), .cmp_ocp(sense_ocp_i), .cmp_min(sense_min_i),
    .end_on(end_on), .ocp_trip(ocp_trip), .olp_trip(olp_trip)
  );

  qrp_demag #(
    .ZCD_BLANK_CYC(ZCD_BLANK_CYC), .CAP_CYC(PER_MAX_CYC), .TW(TW)
  ) u_demag (
    .clk(clk), .rst(rst), .arm_off(turn_off), .clr(fault_go),
    .off_active(state_q == ST_OFF), .zcd_in(aux_zcd_i), .ovp_in(aux_ovp_i),
    .zcd_seen(zcd_seen), .t2(t2), .ovp_trip(ovp_trip)
  );

  qrp_period #(
    .PER_MIN_CYC(PER_MIN_CYC), .PER_MAX_CYC(PER_MAX_CYC), .TW(TW),
    .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .DIM_W(DIM_W), .DIM_FRAC(DIM_FRAC)
  ) u_period (
    .clk(clk), .rst(rst), .restart(turn_on), .preload(fault_go),
    .zcd_seen(zcd_seen), .t2(t2), .gain_code(gain_code_i), .dim_code(dim_code_i),
    .tcnt(tcnt), .on_ok(on_ok)
  );

  qrp_retry #(
    .RETRY_CYC(RETRY_CYC), .RW(RW)
  ) u_retry (
    .clk(clk), .rst(rst), .start(fault_go), .done(retry_done), .busy(retry_busy)
  );

  always_comb begin
    state_n  = state_q;
    turn_on  = 1'b0;
    turn_off = 1'b0;
    fault_go = 1'b0;
    case (state_q)
      ST_ON: begin
        if (ocp_trip) begin
          state_n  = ST_FAULT;
          fault_go = 1'b1;
        end else if (end_on) begin
          if (olp_trip) begin
            state_n  = ST_FAULT;
            fault_go = 1'b1;
          end else begin
            state_n  = ST_OFF;
            turn_off = 1'b1;
          end
        end
      end
      ST_OFF: begin
        if (ovp_trip) begin
          state_n  = ST_FAULT;
          fault_go = 1'b1;
        end else if (on_ok) begin
          state_n = ST_ON;
          turn_on = 1'b1;
        end
      end
      ST_FAULT: if (retry_done) state_n = ST_OFF;
      default:  state_n = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      gate_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      gate_q  <= (state_n == ST_ON);
    end
  end

  assign gate_o = gate_q;

  assert_on_time_max_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ON) |-> (tcnt <= TW'(TON_MAX_CYC - 1)));

  assert_on_time_min_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OFF && $past(state_q) == ST_ON) |-> ($past(tcnt) >= TW'(TON_MIN_CYC - 1)));

  assert_period_floor_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ON && $past(state_q) == ST_OFF && $past(tcnt) != TW'(PER_MAX_CYC))
      |-> ($past(tcnt) >= TW'(PER_MIN_CYC - 1)));

  assert_dim_zero_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ON && $past(state_q) == ST_OFF) |-> ($past(dim_code_i) != '0));

  assert_fault_timer_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FAULT) == retry_busy);
endmodule

// File: tb/qrp_ctrl_tb.sv
module qrp_ctrl_tb;
  localparam int LEB = 4, TMIN = 6, TMAX = 40, ZB = 5;
  localparam int PMIN = 30, PMAX = 300, RET = 200;
  localparam int GW = 6, GF = 2, DW = 5, DF = 4;
  localparam int NEVER = 1000000;

  logic clk = 1'b0, rst = 1'b1;
  logic cmp_peak = 0, cmp_ocp = 0, cmp_min = 0, ovp = 0, zcd = 0;
  logic [GW-1:0] gain = 6'd4;
  logic [DW-1:0] dim = 5'd16;
  logic gate;

  always #2.5 clk = ~clk;

  qrp_ctrl #(
    .LEB_CYC(LEB), .TON_MIN_CYC(TMIN), .TON_MAX_CYC(TMAX), .ZCD_BLANK_CYC(ZB),
    .PER_MIN_CYC(PMIN), .PER_MAX_CYC(PMAX), .RETRY_CYC(RET),
    .GAIN_W(GW), .GAIN_FRAC(GF), .DIM_W(DW), .DIM_FRAC(DF)
  ) u_dut (
    .clk(clk), .rst(rst), .sense_peak_i(cmp_peak), .sense_ocp_i(cmp_ocp),
    .sense_min_i(cmp_min), .aux_ovp_i(ovp), .aux_zcd_i(zcd),
    .gain_code_i(gain), .dim_code_i(dim), .gate_o(gate)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int pk_at = 10, zc_at = 9, ocp_at = NEVER, ovp_at = NEVER, min_en = 1;
  int on_n = 0, off_n = 0, per_n = 0, last_per = 0, last_ton = 0, n_rise = 0;
  bit gate_prev = 0;

  // analog-side model and edge measurement, sampled at the falling clock edge
  always @(negedge clk) begin
    if (rst) begin
      gate_prev = 0; per_n = 0; on_n = 0; off_n = 0;
    end else begin
      if (gate) begin
        if (!gate_prev) begin
          last_per = per_n; per_n = 1; on_n = 0; n_rise = n_rise + 1;
        end else begin
          on_n = on_n + 1; per_n = per_n + 1;
        end
      end else begin
        if (gate_prev) begin
          last_ton = on_n + 1; off_n = 0;
        end else off_n = off_n + 1;
        per_n = per_n + 1;
      end
      gate_prev = gate;
    end
    cmp_peak = gate && (on_n >= pk_at);
    cmp_min  = gate && (min_en != 0);
    cmp_ocp  = gate && (on_n >= ocp_at);
    zcd      = !gate && (off_n >= zc_at);
    ovp      = !gate && (off_n == ovp_at);
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rises(input int n);
    int tgt;
    tgt = n_rise + n;
    while (n_rise < tgt) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic setup(input int pk, input int zc, input int g, input int d,
                       input int mn, input int oc, input int ov);
    pk_at = pk; zc_at = zc; gain = GW'(g); dim = DW'(d);
    min_en = mn; ocp_at = oc; ovp_at = ov;
  endtask

  function automatic int exp_ton(input int pk);
    int k;
    k = pk;
    if (k < LEB) k = LEB;
    if (k < TMIN - 1) k = TMIN - 1;
    if (k > TMAX - 1) k = TMAX - 1;
    return k + 1;
  endfunction

  function automatic int exp_per(input int ton, input int zc, input int g, input int d);
    int t2, p, de, num, den, c;
    if (zc >= NEVER) return PMAX;
    t2 = (zc < ZB) ? ZB : zc;
    de = (d > (1 << DF)) ? (1 << DF) : d;
    num = t2 * g * (1 << DF);
    den = de * (1 << GF);
    c = (num + den - 1) / den;
    p = ton + t2 + 2;
    if (p < PMIN) p = PMIN;
    if (p < c) p = c;
    if (p > PMAX) p = PMAX;
    return p;
  endfunction

  function automatic int gain_sel(input int i);
    case (i) 0: return 0; 1: return 4; 2: return 13; default: return 63; endcase
  endfunction
  function automatic int dim_sel(input int i);
    case (i) 0: return 1; 1: return 6; 2: return 16; default: return 31; endcase
  endfunction
  function automatic int zc_sel(input int i);
    case (i) 0: return 2; 1: return 9; default: return 30; endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (R1..R10 run) actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int t, r0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 gate low in reset", int'(gate), 0);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R1 first edge turn-on", int'(gate), 1);

    // R2: on-time over peak arrival, with blanking and both bounds
    for (int pk = 0; pk <= 45; pk += 3) begin
      setup(pk, 9, 4, 16, 1, NEVER, NEVER);
      wait_rises(3);
      t = exp_ton(pk);
      check("R2 on-time", last_ton, t);
      check("R3 period", last_per, exp_per(t, 9, 4, 16));
    end

    // R3 R4 R5: period law swept over gain, dim, detect time and peak time
    for (int gi = 0; gi < 4; gi++)
      for (int di = 0; di < 4; di++)
        for (int zi = 0; zi < 3; zi++)
          for (int pi = 0; pi < 2; pi++) begin
            setup(pi == 0 ? 1 : 60, zc_sel(zi), gain_sel(gi), dim_sel(di), 1, NEVER, NEVER);
            wait_rises(3);
            t = exp_ton(pk_at);
            check("R4 R5 on-time", last_ton, t);
            check("R3 R4 R5 period", last_per, exp_per(t, zc_at, gain_sel(gi), dim_sel(di)));
          end

    // R10: no zero-current detect
    setup(12, NEVER, 4, 16, 1, NEVER, NEVER);
    wait_rises(3);
    check("R10 max period", last_per, PMAX);

    // R6: overcurrent inside blanking acts at LEB, and later
    setup(60, 9, 4, 16, 1, 1, NEVER);
    wait_rises(3);
    check("R6 ocp blanked on-time", last_ton, LEB + 1);
    check("R6 ocp blanked period", last_per, LEB + 2 + RET);
    setup(60, 9, 4, 16, 1, 10, NEVER);
    wait_rises(3);
    check("R6 ocp on-time", last_ton, 11);
    check("R6 ocp period", last_per, 12 + RET);

    // R7: minimum level never reached
    setup(12, 9, 4, 16, 0, NEVER, NEVER);
    wait_rises(3);
    check("R7 olp on-time", last_ton, 13);
    check("R7 olp period", last_per, 13 + RET + 1);

    // R8: overvoltage ignored in blanking, acts after it
    setup(12, NEVER, 4, 16, 1, NEVER, 3);
    wait_rises(3);
    check("R8 ovp blanked period", last_per, PMAX);
    setup(12, NEVER, 4, 16, 1, NEVER, 8);
    wait_rises(3);
    check("R8 ovp period", last_per, 13 + 8 + 2 + RET);

    // R9: zero dim holds gate off, release restarts at once
    setup(12, 9, 4, 0, 1, NEVER, NEVER);
    r0 = n_rise;
    repeat (700) @(posedge clk);
    #1;
    check("R9 no rise at zero dim", n_rise - r0, 0);
    check("R9 gate low at zero dim", int'(gate), 0);
    dim = DW'(16);
    @(posedge clk); #1;
    check("R9 restart on next edge", int'(gate), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule